// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block talks to a small serial EEPROM of 64 sixteen-bit words over three driven lines (chip select, serial clock, data toward the memory) and one sampled line (data from the memory). A client asks for a read or a write with a one-cycle `start` pulse that carries the direction, a 6-bit word address and, for writes, a 16-bit word. The block raises `busy`, runs the whole serial exchange by itself, and then pulses `done`. After a read, `rdata` holds the word that was fetched.

All serial timing comes from one interval counter. Every wire change is held for `INTERVAL_CYC` system clocks, so a slow part can be met in silicon and a short interval can be used in simulation. A write is always bracketed by an erase/write-enable command before it and a disable command after it. The block detects the end of the internal programming cycle by polling the memory's data line for a bounded number of intervals. If that count runs out, the block flags a timeout and still completes the closing steps.

Top module: `uwire_eeprom_master`

## Requirements
- R1: While reset is asserted and right after it, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `rdata` are all zero.
- R2: A `start` seen while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, and `busy` is low in that same cycle. A `start` that arrives while `busy` is high has no effect on the running operation, on its result, or on the memory contents.
- R3: Each serial bit is sent most significant bit first. `ee_di` is set and held for one interval, `ee_sk` is then high for one interval and low for one interval. `ee_di` never changes while `ee_sk` is high, and it returns to 0 after every field it sends.
- R4: A command starts with `ee_sk` and `ee_di` low for one interval, after which `ee_cs` rises. Whenever `ee_cs` rises, `ee_di` is low.
- R5: A read sends opcode 3'b110 followed by the 6-bit address. It then takes 16 bits MSB first, sampling `ee_do` at the end of each clock-high interval while `ee_di` stays low, and closes with one standby. From the accepting clock edge to the `done` edge it takes 5 + 65·INTERVAL_CYC clocks.
- R6: A write sends, in this order: 5'b10011 plus four zero bits, a standby, 3'b101 with the address and the 16-bit word, a standby, a completion poll, a standby, 5'b10000 plus four zero bits, and a cleanup. The memory holds the new word afterwards and is left write-disabled.
- R7: A standby is four intervals: `ee_cs` and `ee_sk` low, then `ee_sk` high, then `ee_cs` high, then `ee_sk` low. A cleanup drops `ee_cs` and `ee_di` for one interval and then gives one full clock pulse. As a result, a read makes exactly 1 clock pulse with `ee_cs` low, and a write makes exactly 4.
- R8: The poll samples `ee_do` at the end of each interval, at most POLL_MAX times. A high sample ends the poll. If all samples are low, `timeout` is set, the write sequence still finishes, and the whole write takes 10 + (146 + POLL_MAX)·INTERVAL_CYC clocks. `timeout` clears when the next `start` is accepted.
- R9: `rdata` keeps the last word read until another read completes; a write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse, accepted only when idle |
| wr | input | 1 | 1 = write request, 0 = read request |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Word to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last word read |
| timeout | output | 1 | Completion poll expired on the last write |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The assertions assume that `start` only matters while `busy` is low, and that `ee_do` is a level the memory holds steady across an interval. The bench responder therefore changes `ee_do` only at a rising `ee_sk` edge or when the programming timer ends, and never in the middle of a sample. The request fields are assumed stable only in the accepting cycle. The bench drives new, conflicting field values during a busy read to show they are ignored. The sweep writes and reads back every one of the 64 addresses with computed words, and a stuck-busy responder drives the timeout path.

// File: rtl/mw_pkg.sv
// Shared opcodes, state encodings and the segment order for both request kinds.
// Assumes a 3-bit read/write opcode and a 5-bit enable/disable opcode.
package mw_pkg;
    localparam logic [2:0] OP_RD  = 3'b110;
    localparam logic [2:0] OP_WR  = 3'b101;
    localparam logic [4:0] OP_WEN = 5'b10011;
    localparam logic [4:0] OP_WDS = 5'b10000;

    typedef enum logic [1:0] {ST_IDLE, ST_NEXT, ST_RUN} run_st_t;
    typedef enum logic [2:0] {SG_SETUP, SG_OUT, SG_IN, SG_STBY,
                              SG_POLL, SG_CLEAN, SG_END} seg_t;

    // Segment list: write and read share setup, differ afterwards.
    function automatic seg_t seg_of(input logic is_wr, input logic [3:0] idx);
        seg_t s;
        if (is_wr) begin
            case (idx)
                4'd0:    s = SG_SETUP;
                4'd1:    s = SG_OUT;
                4'd2:    s = SG_STBY;
                4'd3:    s = SG_OUT;
                4'd4:    s = SG_STBY;
                4'd5:    s = SG_POLL;
                4'd6:    s = SG_STBY;
                4'd7:    s = SG_OUT;
                4'd8:    s = SG_CLEAN;
                default: s = SG_END;
            endcase
        end else begin
            case (idx)
                4'd0:    s = SG_SETUP;
                4'd1:    s = SG_OUT;
                4'd2:    s = SG_IN;
                4'd3:    s = SG_STBY;
                default: s = SG_END;
            endcase
        end
        return s;
    endfunction
endpackage

// File: rtl/mw_tick.sv
// Interval timer: pulses tick once every INTERVAL_CYC enabled cycles.
// Assumes clr is held whenever a new interval must start from zero.
module mw_tick #(
    parameter int INTERVAL_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL_CYC + 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(INTERVAL_CYC - 1));

    // Count cycles within the current interval.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= '0;
        else if (en)       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mw_seq.sv
// Segment sequencer: walks the segment list of a request and drives the pins.
// Each wire state lasts one tick interval; one idle cycle separates segments.
// Assumes ee_do is stable across an interval.
module mw_seq
    import mw_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int POLL_MAX = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic              ee_do,
    output logic              tick_clr,
    output logic              tick_en,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              timeout,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di
);
    localparam int FW = 3 + ADDR_W + DATA_W;
    localparam int BW = $clog2(FW + 1);
    localparam int PW = $clog2(POLL_MAX + 1);

    run_st_t           st;
    seg_t              seg, nxt_seg;
    logic [3:0]        stage;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [FW-1:0]     sr, fld;
    logic [BW-1:0]     nb, flen;
    logic [1:0]        ph;
    logic [PW-1:0]     pcnt;

    assign nxt_seg  = seg_of(wr_q, stage);
    assign tick_clr = (st != ST_RUN);
    assign tick_en  = (st == ST_RUN);

    // Pick the outgoing field, left-aligned, for the current stage.
    always_comb begin
        flen = BW'(3 + ADDR_W);
        if (!wr_q)
            fld = {OP_RD, addr_q, {DATA_W{1'b0}}};
        else if (stage == 4'd1)
            fld = {OP_WEN, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
        else if (stage == 4'd3) begin
            fld  = {OP_WR, addr_q, wdata_q};
            flen = BW'(FW);
        end else
            fld = {OP_WDS, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
    end

    // Request acceptance, segment entry and per-interval pin stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; seg <= SG_SETUP; stage <= '0; wr_q <= 1'b0;
            addr_q <= '0; wdata_q <= '0; sr <= '0; nb <= '0; ph <= '0;
            pcnt <= '0; rdata <= '0; busy <= 1'b0; done <= 1'b0;
            timeout <= 1'b0; ee_cs <= 1'b0; ee_sk <= 1'b0; ee_di <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    busy <= 1'b1; wr_q <= wr; addr_q <= addr; wdata_q <= wdata;
                    timeout <= 1'b0; stage <= '0; st <= ST_NEXT;
                end
                ST_NEXT: begin
                    seg <= nxt_seg; ph <= '0; st <= ST_RUN;
                    case (nxt_seg)
                        SG_SETUP: begin ee_sk <= 1'b0; ee_di <= 1'b0; end
                        SG_OUT:   begin sr <= fld; nb <= flen; ee_di <= fld[FW-1]; end
                        SG_IN:    begin ee_sk <= 1'b1; ee_di <= 1'b0; nb <= BW'(DATA_W); end
                        SG_STBY:  begin ee_cs <= 1'b0; ee_sk <= 1'b0; end
                        SG_POLL:  pcnt <= '0;
                        SG_CLEAN: begin ee_cs <= 1'b0; ee_di <= 1'b0; end
                        default:  begin busy <= 1'b0; done <= 1'b1; st <= ST_IDLE; end
                    endcase
                end
                ST_RUN: if (tick) begin
                    case (seg)
                        SG_SETUP: if (ph == 2'd0) begin ee_cs <= 1'b1; ph <= 2'd1; end
                                  else begin st <= ST_NEXT; stage <= stage + 1'b1; end
                        SG_OUT: case (ph)
                            2'd0:    begin ee_sk <= 1'b1; ph <= 2'd1; end
                            2'd1:    begin ee_sk <= 1'b0; ph <= 2'd2; end
                            default: if (nb == BW'(1)) begin
                                         ee_di <= 1'b0; st <= ST_NEXT; stage <= stage + 1'b1;
                                     end else begin
                                         sr <= sr << 1; nb <= nb - 1'b1;
                                         ee_di <= sr[FW-2]; ph <= 2'd0;
                                     end
                        endcase
                        SG_IN: if (ph == 2'd0) begin
                                   rdata <= {rdata[DATA_W-2:0], ee_do};
                                   ee_sk <= 1'b0; ph <= 2'd1;
                               end else if (nb == BW'(1)) begin
                                   st <= ST_NEXT; stage <= stage + 1'b1;
                               end else begin
                                   nb <= nb - 1'b1; ee_sk <= 1'b1; ph <= 2'd0;
                               end
                        SG_STBY: case (ph)
                            2'd0:    begin ee_sk <= 1'b1; ph <= 2'd1; end
                            2'd1:    begin ee_cs <= 1'b1; ph <= 2'd2; end
                            2'd2:    begin ee_sk <= 1'b0; ph <= 2'd3; end
                            default: begin st <= ST_NEXT; stage <= stage + 1'b1; end
                        endcase
                        SG_POLL: if (ee_do) begin
                                     st <= ST_NEXT; stage <= stage + 1'b1;
                                 end else if (pcnt == PW'(POLL_MAX - 1)) begin
                                     timeout <= 1'b1; st <= ST_NEXT; stage <= stage + 1'b1;
                                 end else
                                     pcnt <= pcnt + 1'b1;
                        SG_CLEAN: case (ph)
                            2'd0:    begin ee_sk <= 1'b1; ph <= 2'd1; end
                            2'd1:    begin ee_sk <= 1'b0; ph <= 2'd2; end
                            default: begin st <= ST_NEXT; stage <= stage + 1'b1; end
                        endcase
                        default: st <= ST_IDLE;
                    endcase
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uwire_eeprom_master.sv
// Top level: serial EEPROM master built from an interval timer and a sequencer.
// Assumes start is sampled only while busy is low.
module uwire_eeprom_master #(
    parameter int INTERVAL_CYC = 2500,
    parameter int POLL_MAX     = 200,
    parameter int ADDR_W       = 6,
    parameter int DATA_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              timeout,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    logic tick, tick_clr, tick_en;

    mw_tick #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tick_clr), .en(tick_en), .tick(tick)
    );

    mw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_MAX(POLL_MAX)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .addr(addr),
        .wdata(wdata), .tick(tick), .ee_do(ee_do), .tick_clr(tick_clr),
        .tick_en(tick_en), .busy(busy), .done(done), .rdata(rdata),
        .timeout(timeout), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
    );
endmodule

// File: rtl/mw_checker.sv
// Protocol checker for the serial EEPROM master, bound to its top level.
// Assumes a synchronous active-low reset.
module mw_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic timeout,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R2
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R2
    AST_PINS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> ($stable(ee_cs) && $stable(ee_sk) && $stable(ee_di))); // R2
    AST_DI_HELD_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> $stable(ee_di)); // R3
    AST_CS_RISE_DI_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_cs) |-> !ee_di); // R4
    AST_TIMEOUT_IN_OP: assert property (@(posedge clk) disable iff (!rst_n) $rose(timeout) |-> busy); // R8
endmodule

bind uwire_eeprom_master mw_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .timeout(timeout), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/uwire_eeprom_master_bench.sv
// Bench: behavioural EEPROM responder, full address sweep, timeout path.
module uwire_eeprom_master_bench;
    localparam int IV = 4;
    localparam int PM = 20;
    localparam int WB = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic busy, done, timeout, ee_cs, ee_sk, ee_di, ee_do;
    logic [15:0] rdata;

    always #4 clk = ~clk;

    uwire_eeprom_master #(.INTERVAL_CYC(IV), .POLL_MAX(PM)) u_uwire_eeprom_master (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .addr(addr),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
        .timeout(timeout), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .ee_do(ee_do)
    );

    int nvec = 0, nbad = 0;
    bit fin = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Responder state
    logic [15:0] mem [64];
    logic [24:0] bits = '0;
    int nbit = 0;
    bit rd_mode = 0, wen = 0, pend = 0, stuck = 0, obit = 0;
    logic [15:0] osr = '0;
    logic [5:0]  paddr = '0;
    logic [15:0] pdata = '0;
    longint cyc = 0, ready_at = 0;
    int lowp = 0, v3 = 0, v4 = 0, v5 = 0, ewen_seen = 0;

    assign ee_do = ee_cs && (rd_mode ? obit : ((cyc >= ready_at) && !stuck));

    always @(posedge clk) cyc <= cyc + 1;

    // Responder: shift in on rising clock, decode commands, drive read bits.
    always @(posedge ee_sk) begin
        if (!ee_cs) lowp++;
        else begin
            bits = {bits[23:0], ee_di};
            nbit++;
            if (rd_mode && nbit > 9) begin
                if (ee_di) v5++;
                obit = osr[15];
                osr = osr << 1;
            end
            if (nbit == 9) begin
                if (bits[8:6] == 3'b110) begin rd_mode = 1; osr = mem[bits[5:0]]; end
                if (bits[8:4] == 5'b10011) begin wen = 1; ewen_seen++; end
                if (bits[8:4] == 5'b10000) wen = 0;
            end
            if (nbit == 25 && bits[24:22] == 3'b101) begin
                pend = 1; paddr = bits[21:16]; pdata = bits[15:0];
            end
        end
    end

    // Responder: chip select low ends a command and commits a pending write.
    always @(negedge ee_cs) begin
        if (pend && wen) begin mem[paddr] = pdata; ready_at = cyc + WB; end
        pend = 0; nbit = 0; rd_mode = 0; bits = '0;
    end

    always @(ee_di) if (ee_sk === 1'b1) v3++;
    always @(posedge ee_cs) if (ee_di) v4++;

    function automatic logic [15:0] pat(input int a, input int k);
        return 16'((a * 16'h9E37) ^ (k * 16'h3C1B) ^ 16'hA5C3);
    endfunction

    task automatic op(input bit w, input int a, input logic [15:0] d, output int nb);
        @(negedge clk);
        start = 1'b1; wr = w; addr = 6'(a); wdata = d;
        @(negedge clk);
        start = 1'b0;
        nb = 0;
        while (!done) begin
            if (busy) nb++;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input int a, input logic [15:0] d);
        int nb, lp0, ew0;
        lp0 = lowp; ew0 = ewen_seen;
        op(1'b1, a, d, nb);
        chk(lowp - lp0 == 4, "R7 write low-cs pulses", 32'(lowp - lp0), 4);
        chk(!wen && ewen_seen == ew0 + 1, "R6 enable/disable wrap", {wen, 31'(ewen_seen - ew0)}, 1);
        chk(mem[a] == d, "R6 word stored", mem[a], d);
        chk(!timeout, "R8 no timeout on ready part", timeout, 0);
    endtask

    task automatic do_read(input int a, input logic [15:0] exp);
        int nb, lp0;
        lp0 = lowp;
        op(1'b0, a, 16'h0, nb);
        chk(rdata == exp, "R5 read word", rdata, exp);
        chk(nb == 5 + 65 * IV, "R5 read latency", nb, 5 + 65 * IV);
        chk(lowp - lp0 == 1, "R7 read low-cs pulses", 32'(lowp - lp0), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            nbad++; nvec++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        int nb;
        logic [15:0] last;
        for (int i = 0; i < 64; i++) mem[i] = 16'(i * 3 + 16'h1000);
        repeat (3) @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy, done} == 5'b0 && rdata == 16'h0, "R1 reset state",
            {ee_cs, ee_sk, ee_di, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy, done} == 5'b0, "R1 after reset", {ee_cs, ee_sk, ee_di, busy, done}, 0);

        for (int a = 0; a < 64; a += 9) do_read(a, 16'(a * 3 + 16'h1000));
        for (int a = 0; a < 64; a++) do_write(a, pat(a, 0));
        for (int a = 0; a < 64; a++) do_read(a, pat(a, 0));
        for (int a = 0; a < 64; a += 7) begin
            do_write(a, ~pat(a, 1));
            do_read(a, ~pat(a, 1));
        end
        do_write(0, 16'hFFFF); do_read(0, 16'hFFFF);
        do_write(63, 16'h0000); do_read(63, 16'h0000);
        do_write(42, 16'h8001); do_read(42, 16'h8001);

        // R9: a write leaves rdata unchanged
        last = rdata;
        do_write(5, 16'h1357);
        chk(rdata == last, "R9 rdata held across write", rdata, last);

        // R2: start during a busy read is ignored
        @(negedge clk);
        start = 1'b1; wr = 1'b0; addr = 6'd5;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1; wr = 1'b1; addr = 6'd9; wdata = 16'hDEAD;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk(rdata == 16'h1357, "R2 busy start ignored, result", rdata, 16'h1357);
        @(negedge clk);
        chk(!done, "R2 done one cycle", done, 0);
        nb = 0;
        repeat (10) begin if (busy) nb++; @(negedge clk); end
        chk(nb == 0, "R2 no second op", nb, 0);
        do_read(9, pat(9, 0));

        // R8: stuck part drives the timeout path
        stuck = 1;
        op(1'b1, 7, 16'h1234, nb);
        chk(timeout, "R8 timeout flag", timeout, 1);
        chk(nb == 10 + (146 + PM) * IV, "R8 timeout duration", nb, 10 + (146 + PM) * IV);
        chk(!wen, "R8 disable still sent", wen, 0);
        stuck = 0;
        op(1'b0, 7, 16'h0, nb);
        chk(!timeout, "R8 timeout cleared", timeout, 1'b0);

        chk(v3 == 0, "R3 di stable while sk high", v3, 0);
        chk(v4 == 0, "R4 di low at cs rise", v4, 0);
        chk(v5 == 0, "R5 di low while shifting in", v5, 0);

        fin = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule